// File: doc/BRIEF.md
# Acquisition FIFO Status Flags and Interrupt Request

This block sits beside the sample FIFOs of a data-acquisition board and turns their raw status lines into a status word for the host. It watches four signals: the converter FIFO's empty and full lines, the converter FIFO's write strobe, and the output FIFO's empty line. From these it builds one live flag and three sticky flags. The live flag shows whether the converter FIFO holds data right now. The sticky flags record three events: data arriving in an empty FIFO, a write arriving while the FIFO is full, and the output FIFO draining to empty.

The host reads all four flags in one word, with each flag at a fixed bit. The host clears each sticky flag with its own one-cycle strobe. A FIFO reset clears all three sticky flags at once. Two of the sticky flags, data-ready and output-drained, each have an enable input. The block raises a single interrupt request whenever an enabled sticky flag is set. Every input is sampled on the rising clock edge. Reset is synchronous and active low.

Top module: `acq_fifo_flags`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the status word reads 4'h0 and irq_o is 0, provided the converter FIFO is empty at that time.
- R2: Status bit 0 (live data) equals the inverse of adc_empty_i in the same cycle, with no clock delay.
- R3: Status bit 1 (data-ready) becomes 1 at the first clock edge where adc_empty_i is sampled 0 after having been sampled 1 at the previous edge. Immediately after reset the FIFO counts as having been empty.
- R4: Data-ready becomes 0 at any clock edge where adc_empty_i is sampled 1. Once cleared while data remains, it stays 0 until the FIFO has gone empty and then received data again.
- R5: Status bit 2 (overflow) becomes 1 at a clock edge where adc_wr_i and adc_full_i are both 1. Either signal alone does not set it.
- R6: Overflow, once set, holds its value through any number of idle cycles until it is cleared by clr_ovf_i or fifo_rst_i.
- R7: Status bit 3 (output drained) becomes 1 at a clock edge where dac_empty_i is sampled 1 after being sampled 0 at the previous edge. If dac_empty_i stays at 1, the flag is not set again after a clear.
- R8: The host clear strobes clr_ne_i, clr_ovf_i and clr_dae_i each clear only their own flag (bit 1, bit 2 and bit 3) at the next clock edge.
- R9: When a host clear strobe and a set event for the same flag occur at the same edge, the flag ends up 1.
- R10: fifo_rst_i clears bits 1, 2 and 3 at the next clock edge. This overrides any set event at that edge.
- R11: irq_o = (bit 1 AND ie_ne_i) OR (bit 3 AND ie_dae_i). The enable inputs act combinationally. The overflow flag never drives irq_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_empty_i | input | 1 | Converter FIFO empty |
| adc_full_i | input | 1 | Converter FIFO full |
| adc_wr_i | input | 1 | Converter FIFO write strobe |
| dac_empty_i | input | 1 | Output FIFO empty |
| fifo_rst_i | input | 1 | FIFO reset; clears all sticky flags |
| clr_ne_i | input | 1 | Host clear of data-ready flag |
| clr_ovf_i | input | 1 | Host clear of overflow flag |
| clr_dae_i | input | 1 | Host clear of output-drained flag |
| ie_ne_i | input | 1 | Interrupt enable for data-ready |
| ie_dae_i | input | 1 | Interrupt enable for output-drained |
| status_o | output | 4 | Status word: bit0 live, bit1 data-ready, bit2 overflow, bit3 output-drained |
| irq_o | output | 1 | Interrupt request |

## Verification
Some rules hold on every clock cycle, and the assertions check those continuously. They cover the priority inside each sticky cell: FIFO reset first, then a set event, then a clear. They cover holding the value when nothing happens, the automatic clearing of data-ready whenever the FIFO is empty, and overflow setting whenever a write meets a full FIFO. They also check that irq_o stays quiet when neither interrupt-capable flag is set. Two kinds of behaviour only the bench scenarios can show. The first is the edge-based nature of the data-ready and drained flags: a flag must not be set again while its level stays put. The second is that each clear strobe leaves the other flags alone, and that the enables gate the request.

// File: rtl/acq_flags_pkg.sv
// Package: shared indices and widths for the acquisition FIFO status block.
// Assumes a single status word with fixed bit positions read by the host.
package acq_flags_pkg;
    // Sticky flag indices inside the internal sticky vector
    localparam int unsigned NUM_STICKY = 3;
    localparam int unsigned IDX_NE     = 0;
    localparam int unsigned IDX_OVF    = 1;
    localparam int unsigned IDX_DAE    = 2;

    // Bit positions in the host status word
    localparam int unsigned STATUS_W   = NUM_STICKY + 1;
    localparam int unsigned ST_LIVE    = 0;
    localparam int unsigned ST_NE      = 1;
    localparam int unsigned ST_OVF     = 2;
    localparam int unsigned ST_DAE     = 3;

    // Edge detector lanes
    localparam int unsigned NUM_EDGE   = 2;
    localparam int unsigned EDGE_NE    = 0;
    localparam int unsigned EDGE_DAE   = 1;
endpackage

// File: rtl/acq_edge_det.sv
// Module: rising-edge detector over a vector of level signals.
// Assumes inputs are synchronous to clk. The registered history resets to
// IDLE_VAL so that no edge is reported for lanes already at their idle level.
module acq_edge_det #(
    parameter int unsigned          W        = 2,
    parameter logic [W-1:0]         IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] hist_q;

    // Keep the level seen at the previous clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= IDLE_VAL;
        else        hist_q <= lvl_i;
    end

    // A lane pulses when it is high now and was low at the last edge
    always_comb rise_o = lvl_i & ~hist_q;
endmodule

// File: rtl/acq_sticky_bit.sv
// Module: one sticky status flag with a fixed priority.
// Priority: hard clear (FIFO reset) > set event > host/auto clear > hold.
// Assumes all strobes are one-cycle wide and synchronous to clk.
module acq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic host_clr_i,
    input  logic auto_clr_i,
    input  logic hard_clr_i,
    output logic q_o
);
    logic q_q;

    // Update the flag according to the priority order above
    always_ff @(posedge clk) begin
        if (!rst_n)                       q_q <= 1'b0;
        else if (hard_clr_i)              q_q <= 1'b0;
        else if (set_i)                   q_q <= 1'b1;
        else if (host_clr_i || auto_clr_i) q_q <= 1'b0;
    end

    assign q_o = q_q;

    // Set event beats any soft clear (R9)
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !hard_clr_i) |=> q_o);

    // FIFO reset always clears (R10)
    assert_hard_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr_i |=> !q_o);

    // Soft clear without set clears the flag (R8)
    assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_clr_i || auto_clr_i) && !set_i && !hard_clr_i) |=> !q_o);

    // With no event the flag holds (R6)
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !host_clr_i && !auto_clr_i && !hard_clr_i) |=> $stable(q_o));
endmodule

// File: rtl/acq_irq_gate.sv
// Module: combines sticky flags with per-flag enables into one request.
// Assumes flags without an enable are masked by tying their enable to 0.
module acq_irq_gate #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         req_o
);
    // OR of all enabled flags
    always_comb req_o = |(flag_i & en_i);
endmodule

// File: rtl/acq_fifo_flags.sv
// Module: status flags and interrupt request for the acquisition FIFOs.
// Builds a live data flag and three sticky flags (data-ready, overflow,
// output drained), packs them in one status word and raises irq_o.
// Assumes all inputs synchronous to clk; reading status_o has no side effect.
module acq_fifo_flags
    import acq_flags_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adc_empty_i,
    input  logic                adc_full_i,
    input  logic                adc_wr_i,
    input  logic                dac_empty_i,
    input  logic                fifo_rst_i,
    input  logic                clr_ne_i,
    input  logic                clr_ovf_i,
    input  logic                clr_dae_i,
    input  logic                ie_ne_i,
    input  logic                ie_dae_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                irq_o
);
    localparam logic [NUM_EDGE-1:0] EDGE_IDLE = NUM_EDGE'(1) << EDGE_DAE;

    logic [NUM_EDGE-1:0]   lvl;
    logic [NUM_EDGE-1:0]   rise;
    logic [NUM_STICKY-1:0] set_v;
    logic [NUM_STICKY-1:0] hclr_v;
    logic [NUM_STICKY-1:0] aclr_v;
    logic [NUM_STICKY-1:0] ie_v;
    logic [NUM_STICKY-1:0] sticky;

    // Levels whose rising edge marks an event
    always_comb begin
        lvl           = '0;
        lvl[EDGE_NE]  = !adc_empty_i;
        lvl[EDGE_DAE] = dac_empty_i;
    end

    acq_edge_det #(.W(NUM_EDGE), .IDLE_VAL(EDGE_IDLE)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .rise_o (rise)
    );

    // Per-flag set, host clear, auto clear and enable vectors
    always_comb begin
        set_v           = '0;
        hclr_v          = '0;
        aclr_v          = '0;
        ie_v            = '0;
        set_v[IDX_NE]   = rise[EDGE_NE];
        set_v[IDX_OVF]  = adc_wr_i && adc_full_i;
        set_v[IDX_DAE]  = rise[EDGE_DAE];
        hclr_v[IDX_NE]  = clr_ne_i;
        hclr_v[IDX_OVF] = clr_ovf_i;
        hclr_v[IDX_DAE] = clr_dae_i;
        aclr_v[IDX_NE]  = adc_empty_i;
        ie_v[IDX_NE]    = ie_ne_i;
        ie_v[IDX_DAE]   = ie_dae_i;
    end

    for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
        acq_sticky_bit u_bit (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (set_v[g]),
            .host_clr_i (hclr_v[g]),
            .auto_clr_i (aclr_v[g]),
            .hard_clr_i (fifo_rst_i),
            .q_o        (sticky[g])
        );
    end

    acq_irq_gate #(.N(NUM_STICKY)) u_irq (
        .flag_i (sticky),
        .en_i   (ie_v),
        .req_o  (irq_o)
    );

    // Pack the host status word at fixed positions
    always_comb begin
        status_o          = '0;
        status_o[ST_LIVE] = !adc_empty_i;
        status_o[ST_NE]   = sticky[IDX_NE];
        status_o[ST_OVF]  = sticky[IDX_OVF];
        status_o[ST_DAE]  = sticky[IDX_DAE];
    end

    // Empty FIFO always leaves data-ready low at the next edge (R4)
    assert_ne_autoclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_empty_i |=> !status_o[ST_NE]);

    // Write into a full FIFO records overflow (R5)
    assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_wr_i && adc_full_i && !fifo_rst_i) |=> status_o[ST_OVF]);

    // No interrupt without an interrupt-capable flag (R11)
    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[ST_NE] && !status_o[ST_DAE]) |-> !irq_o);
endmodule

// File: tb/sim_acq_fifo_flags.sv
module sim_acq_fifo_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adc_empty_i, adc_full_i, adc_wr_i, dac_empty_i, fifo_rst_i;
    logic       clr_ne_i, clr_ovf_i, clr_dae_i, ie_ne_i, ie_dae_i;
    logic [3:0] status_o;
    logic       irq_o;
    int         n_vec = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    acq_fifo_flags u0 (.*);

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        adc_empty_i = 1; adc_full_i = 0; adc_wr_i = 0; dac_empty_i = 1;
        fifo_rst_i = 0; clr_ne_i = 0; clr_ovf_i = 0; clr_dae_i = 0;
        ie_ne_i = 0; ie_dae_i = 0;
    endtask

    task automatic clean();
        idle(); fifo_rst_i = 1; tick(); fifo_rst_i = 0;
    endtask

    task automatic t_reset();
        idle(); rst_n = 0; tick(); tick();
        check("R1 status in reset", status_o, 4'h0);
        check("R1 irq in reset", {3'b0, irq_o}, 4'h0);
        rst_n = 1; tick();
        check("R1 status after reset", status_o, 4'h0);
    endtask

    task automatic t_live_latch();
        clean();
        adc_empty_i = 0; #1;
        check("R2 live bit same cycle", {3'b0, status_o[0]}, 4'h1);
        check("R3 not yet latched", {3'b0, status_o[1]}, 4'h0);
        tick(); check("R3 data-ready set", {3'b0, status_o[1]}, 4'h1);
        tick(); check("R3 data-ready held", {3'b0, status_o[1]}, 4'h1);
        adc_empty_i = 1; #1;
        check("R2 live bit falls", {3'b0, status_o[0]}, 4'h0);
        tick(); check("R4 auto clear on empty", {3'b0, status_o[1]}, 4'h0);
    endtask

    task automatic t_clear_ne();
        clean();
        adc_empty_i = 0; tick();
        clr_ne_i = 1; tick(); clr_ne_i = 0;
        check("R8 host clear data-ready", status_o, 4'h1);
        tick(); check("R4 no re-set while data stays", status_o, 4'h1);
        adc_empty_i = 1; tick(); adc_empty_i = 0; tick();
        check("R3 set on new arrival", status_o, 4'h3);
        adc_empty_i = 1; tick();
        check("R4 cleared on empty", status_o, 4'h0);
    endtask

    task automatic t_overflow();
        clean();
        adc_full_i = 1; tick();
        check("R5 full alone", {3'b0, status_o[2]}, 4'h0);
        adc_full_i = 0; adc_wr_i = 1; tick();
        check("R5 write alone", {3'b0, status_o[2]}, 4'h0);
        adc_full_i = 1; tick();
        check("R5 write while full", {3'b0, status_o[2]}, 4'h1);
        adc_full_i = 0; adc_wr_i = 0;
        repeat (5) tick();
        check("R6 overflow held", {3'b0, status_o[2]}, 4'h1);
        clr_ne_i = 1; clr_dae_i = 1; tick(); clr_ne_i = 0; clr_dae_i = 0;
        check("R8 other clears ignore overflow", status_o, 4'h4);
        clr_ovf_i = 1; tick(); clr_ovf_i = 0;
        check("R6 cleared by host", status_o, 4'h0);
    endtask

    task automatic t_dac();
        clean();
        dac_empty_i = 0; tick();
        check("R7 not drained yet", {3'b0, status_o[3]}, 4'h0);
        dac_empty_i = 1; tick();
        check("R7 drained set", status_o, 4'h8);
        tick(); check("R7 drained held", status_o, 4'h8);
        clr_dae_i = 1; tick(); clr_dae_i = 0;
        check("R8 drained host clear", status_o, 4'h0);
        repeat (3) tick();
        check("R7 level does not re-set", status_o, 4'h0);
    endtask

    task automatic t_priority();
        clean();
        adc_full_i = 1; adc_wr_i = 1; clr_ovf_i = 1; tick();
        adc_full_i = 0; adc_wr_i = 0; clr_ovf_i = 0;
        check("R9 overflow set beats clear", {3'b0, status_o[2]}, 4'h1);
        adc_empty_i = 0; clr_ne_i = 1; tick(); clr_ne_i = 0;
        check("R9 data-ready set beats clear", {3'b0, status_o[1]}, 4'h1);
        adc_empty_i = 1; dac_empty_i = 0; tick();
        dac_empty_i = 1; clr_dae_i = 1; tick(); clr_dae_i = 0;
        check("R9 drained set beats clear", {3'b0, status_o[3]}, 4'h1);
    endtask

    task automatic t_fifo_reset();
        clean();
        adc_empty_i = 0; adc_full_i = 1; adc_wr_i = 1; dac_empty_i = 0; tick();
        dac_empty_i = 1; adc_wr_i = 0; tick();
        check("R10 setup all set", status_o, 4'hF);
        dac_empty_i = 0; tick();
        fifo_rst_i = 1; adc_wr_i = 1; dac_empty_i = 1; tick();
        fifo_rst_i = 0; adc_wr_i = 0; adc_full_i = 0;
        check("R10 reset overrides sets", status_o, 4'h1);
    endtask

    task automatic t_irq();
        clean();
        adc_empty_i = 0; tick();
        ie_ne_i = 0; #1; check("R11 data-ready masked", {3'b0, irq_o}, 4'h0);
        ie_ne_i = 1; #1; check("R11 data-ready enabled", {3'b0, irq_o}, 4'h1);
        ie_ne_i = 0; adc_empty_i = 1; tick();
        adc_full_i = 1; adc_wr_i = 1; tick(); adc_full_i = 0; adc_wr_i = 0;
        ie_ne_i = 1; ie_dae_i = 1; #1;
        check("R11 overflow gives no irq", {3'b0, irq_o}, 4'h0);
        dac_empty_i = 0; tick(); dac_empty_i = 1; tick();
        check("R11 drained enabled", {3'b0, irq_o}, 4'h1);
        ie_dae_i = 0; #1;
        check("R11 drained masked", {3'b0, irq_o}, 4'h0);
        clean();
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle();
        t_reset();
        t_live_latch();
        t_clear_ne();
        t_overflow();
        t_dac();
        t_priority();
        t_fifo_reset();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule